// File: doc/BRIEF.md
# Semaphore Wait-and-Update Executor

This block runs one fused synchronization instruction at a time against a bank of 256 unsigned 32-bit counters and a separate 256-bit event vector. The instruction arrives as a 512-bit word over a valid/ready handshake. Each word can hold:

- up to two blocking "counter at least threshold" conditions;
- one update, which either changes a counter or sets an event bit.

The block holds the instruction until every used condition is true. It then applies the update and pulses a retire strobe. An error strobe accompanies the retire when the word is malformed.

Thresholds come either from the instruction itself or from an external register file. The block reads that register file through two combinational read ports, one for each condition. Other engines can bump any counter by one through a signal port. An observation port lets the surrounding logic read any counter combinationally. The event vector is a direct output.

The controller has two states:

- **IDLE**: `in_ready` is high. The transition *accept* (`in_valid` high) captures the decoded word and moves to WAIT.
- **WAIT**: `in_ready` is low. There are two ways back to IDLE:
  - *fault*: the word is malformed. The block retires with the error flag set and makes no change.
  - *release*: every used condition holds. The update is committed on that clock edge, and the block retires.

WAIT holds itself while any condition is still false.

Top module: `sem_exec_top`

## Requirements
- R1: Byte 0 of the word must be 0xA0, byte 1 must be 0x10, and bytes 2 and 3 must be zero (byte k is bits 8k+7..8k). Any other header makes the instruction retire with `err` high and no counter or event change.
- R2: After reset, `in_ready`=1, `retire`=0, `err`=0, all counters read 0 and all event bits are 0. `in_ready` is high only in IDLE. A word is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low for the following cycle.
- R3: Condition A is described by three fields: mode at byte 0x04, counter index at byte 0x05, and a 32-bit little-endian threshold at bytes 0x08–0x0B. Condition B uses mode at byte 0x20, index at 0x21 and threshold at 0x24–0x27. Mode 0x00 marks a condition as unused; an unused condition always holds.
- R4: Mode 0x05 holds the instruction until the indexed counter, compared as unsigned, is greater than or equal to the threshold field.
- R5: Mode 0x85 (bit 7 set) compares against a register instead of the field itself. The register index is the low RF_AW bits of the threshold field. Condition A reads through `rf_addr0`/`rf_data0`, and condition B reads through `rf_addr1`/`rf_data1`.
- R6: A condition mode other than 0x00, 0x05 or 0x85 (for example 0x01 or 0x07) is illegal. The instruction retires on the cycle after acceptance with `err` high and no side effect.
- R7: The update mode is at byte 0x22, its index at byte 0x23, and its 32-bit little-endian value at bytes 0x28–0x2B. The counter update codes are: 0x15 adds the value, 0x17 subtracts it, 0x19 overwrites the counter with it, 0x13 adds one, and 0x14 subtracts one. Arithmetic wraps modulo 2^32.
- R8: For codes 0x13 and 0x14 the value field has no effect on the result.
- R9: Code 0x11 sets the indexed bit of `evt_bits` and leaves every counter unchanged. Event bits stay set until reset, and they change only in a cycle where `retire` is high without `err`.
- R10: Update code 0x00 means no update. Any other code outside the listed set makes the instruction retire on the cycle after acceptance with `err` high and no side effect. `err` is never high without `retire`.
- R11: The update is committed on the same clock edge at which the last condition becomes true, and never earlier. `retire` is high for exactly the one cycle after that edge. An instruction with no used conditions retires in the cycle after the one following acceptance.
- R12: With `sig_valid` high, the counter at `sig_idx` gains one at the clock edge. Conditions evaluated at that same edge see the value from before the bump. When the bump and an instruction update hit the same counter at the same edge, the final value is the update result plus one.
- R13: `sem_rd_data` always equals the current value of the counter selected by `sem_rd_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_insn | input | 512 | Instruction word, byte k at bits 8k+7..8k |
| rf_addr0 | output | RF_AW (4) | Register index for condition A |
| rf_data0 | input | 32 | Register value for condition A |
| rf_addr1 | output | RF_AW (4) | Register index for condition B |
| rf_data1 | input | 32 | Register value for condition B |
| sig_valid | input | 1 | Increment request from another engine |
| sig_idx | input | 8 | Counter to increment |
| sem_rd_idx | input | 8 | Counter selected for observation |
| sem_rd_data | output | 32 | Value of the observed counter |
| evt_bits | output | 256 | Event vector |
| retire | output | 1 | One-cycle pulse when an instruction finishes |
| err | output | 1 | Malformed instruction, valid with retire |

## Verification
Two things can land on the same counter at the same clock edge: the instruction's release update and an external increment. The bench provokes this in three ways:

- It raises `sig_valid` on the target counter at exactly the release edge, once for an overwrite and once for an increment.
- It bumps a counter that a pending condition watches, at the first edge after acceptance, to show that the condition still sees the old value and the release waits one more edge.

A behavioural reference model applies the update first and the bump second, in plain sequential code. Its counters, events, retire and error are compared with the outputs on every clock, alongside direct value checks after each such collision.

// File: rtl/sem_exec_pkg.sv
package sem_exec_pkg;

    localparam int unsigned SEM_IDX_W = 8;
    localparam int unsigned SEM_VAL_W = 32;
    localparam int unsigned SEM_NUM   = 1 << SEM_IDX_W;
    localparam int unsigned INSN_W    = 512;
    localparam int unsigned N_COND    = 2;

    localparam logic [7:0] HDR_OPC  = 8'hA0;
    localparam logic [7:0] HDR_LEN  = 8'h10;

    localparam logic [7:0] CM_OFF    = 8'h00;
    localparam logic [7:0] CM_GE_IMM = 8'h05;
    localparam logic [7:0] CM_GE_REG = 8'h85;

    localparam logic [7:0] UC_NONE = 8'h00;
    localparam logic [7:0] UC_EVT  = 8'h11;
    localparam logic [7:0] UC_INC  = 8'h13;
    localparam logic [7:0] UC_DEC  = 8'h14;
    localparam logic [7:0] UC_ADD  = 8'h15;
    localparam logic [7:0] UC_SUB  = 8'h17;
    localparam logic [7:0] UC_WR   = 8'h19;

    typedef enum logic [2:0] {
        OP_NONE, OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_WR, OP_EVT
    } upd_op_e;

    typedef struct packed {
        logic [7:0]           mode;
        logic [SEM_IDX_W-1:0] idx;
        logic [SEM_VAL_W-1:0] thr;
    } cond_t;

    typedef struct packed {
        upd_op_e              op;
        logic [SEM_IDX_W-1:0] idx;
        logic [SEM_VAL_W-1:0] val;
    } upd_cmd_t;

    typedef enum logic {
        ST_IDLE,
        ST_WAIT
    } exec_state_e;

endpackage

// File: rtl/sem_exec_decode.sv
module sem_exec_decode
    import sem_exec_pkg::*;
(
    input  logic [INSN_W-1:0]        insn,
    output cond_t [N_COND-1:0]       conds,
    output upd_cmd_t                 upd,
    output logic                     bad
);

    localparam int unsigned UPD_MODE_B = 34;
    localparam int unsigned UPD_IDX_B  = 35;
    localparam int unsigned UPD_VAL_B  = 40;

    logic [N_COND-1:0] cond_bad;
    logic              hdr_bad;
    logic              upd_bad;
    logic [7:0]        upd_code;

    genvar k;
    generate
        for (k = 0; k < N_COND; k++) begin : g_cond
            localparam int unsigned MB = (k == 0) ? 4 : 32;
            localparam int unsigned TB = (k == 0) ? 8 : 36;
            assign conds[k].mode = insn[8*MB +: 8];
            assign conds[k].idx  = insn[8*(MB+1) +: SEM_IDX_W];
            assign conds[k].thr  = insn[8*TB +: SEM_VAL_W];
            assign cond_bad[k]   = !(conds[k].mode == CM_OFF ||
                                     conds[k].mode == CM_GE_IMM ||
                                     conds[k].mode == CM_GE_REG);
        end
    endgenerate

    assign hdr_bad  = (insn[7:0] != HDR_OPC) || (insn[15:8] != HDR_LEN) ||
                      (insn[31:16] != 16'h0000);
    assign upd_code = insn[8*UPD_MODE_B +: 8];
    assign upd.idx  = insn[8*UPD_IDX_B +: SEM_IDX_W];
    assign upd.val  = insn[8*UPD_VAL_B +: SEM_VAL_W];

    always_comb begin
        upd_bad = 1'b0;
        case (upd_code)
            UC_NONE: upd.op = OP_NONE;
            UC_ADD:  upd.op = OP_ADD;
            UC_SUB:  upd.op = OP_SUB;
            UC_INC:  upd.op = OP_INC;
            UC_DEC:  upd.op = OP_DEC;
            UC_WR:   upd.op = OP_WR;
            UC_EVT:  upd.op = OP_EVT;
            default: begin
                upd.op  = OP_NONE;
                upd_bad = 1'b1;
            end
        endcase
    end

    assign bad = hdr_bad | (|cond_bad) | upd_bad;

    logic unused_reserved;
    assign unused_reserved = ^{insn[INSN_W-1:8*44], insn[8*12 +: 8*20], insn[8*6 +: 16]};

endmodule

// File: rtl/sem_exec_cond.sv
module sem_exec_cond
    import sem_exec_pkg::*;
#(
    parameter int unsigned RF_AW = 4
) (
    input  logic [7:0]           mode,
    input  logic [SEM_VAL_W-1:0] thr,
    input  logic [SEM_VAL_W-1:0] cnt,
    input  logic [SEM_VAL_W-1:0] rf_data,
    output logic [RF_AW-1:0]     rf_addr,
    output logic                 met
);

    logic [SEM_VAL_W-1:0] limit;

    assign rf_addr = thr[RF_AW-1:0];
    assign limit   = mode[7] ? rf_data : thr;
    assign met     = (mode == CM_OFF) || (cnt >= limit);

endmodule

// File: rtl/sem_exec_bank.sv
module sem_exec_bank
    import sem_exec_pkg::*;
#(
    parameter int unsigned NRD = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            apply,
    input  upd_cmd_t                        cmd,
    input  logic                            sig_valid,
    input  logic [SEM_IDX_W-1:0]            sig_idx,
    input  logic [NRD-1:0][SEM_IDX_W-1:0]   rd_idx,
    output logic [NRD-1:0][SEM_VAL_W-1:0]   rd_data,
    input  logic [SEM_IDX_W-1:0]            obs_idx,
    output logic [SEM_VAL_W-1:0]            obs_data,
    output logic [SEM_NUM-1:0]              evt_bits
);

    logic [SEM_VAL_W-1:0] cnt_q [SEM_NUM];
    logic [SEM_NUM-1:0]   evt_q;
    logic [SEM_VAL_W-1:0] old_v;
    logic [SEM_VAL_W-1:0] res_v;
    logic                 is_cnt;
    logic                 hit;
    logic                 same;

    assign old_v  = cnt_q[cmd.idx];
    assign is_cnt = (cmd.op != OP_NONE) && (cmd.op != OP_EVT);
    assign hit    = apply && is_cnt;
    assign same   = sig_valid && (sig_idx == cmd.idx);

    always_comb begin
        case (cmd.op)
            OP_ADD:  res_v = old_v + cmd.val;
            OP_SUB:  res_v = old_v - cmd.val;
            OP_INC:  res_v = old_v + 32'd1;
            OP_DEC:  res_v = old_v - 32'd1;
            OP_WR:   res_v = cmd.val;
            default: res_v = old_v;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SEM_NUM; i++) cnt_q[i] <= '0;
            evt_q <= '0;
        end else begin
            if (hit) cnt_q[cmd.idx] <= res_v + SEM_VAL_W'(same);
            if (sig_valid && !(hit && same)) cnt_q[sig_idx] <= cnt_q[sig_idx] + 32'd1;
            if (apply && cmd.op == OP_EVT) evt_q[cmd.idx] <= 1'b1;
        end
    end

    genvar k;
    generate
        for (k = 0; k < NRD; k++) begin : g_rd
            assign rd_data[k] = cnt_q[rd_idx[k]];
        end
    endgenerate

    assign obs_data = cnt_q[obs_idx];
    assign evt_bits = evt_q;

endmodule

// File: rtl/sem_exec_top.sv
module sem_exec_top
    import sem_exec_pkg::*;
#(
    parameter int unsigned RF_AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [INSN_W-1:0]     in_insn,
    output logic [RF_AW-1:0]      rf_addr0,
    input  logic [SEM_VAL_W-1:0]  rf_data0,
    output logic [RF_AW-1:0]      rf_addr1,
    input  logic [SEM_VAL_W-1:0]  rf_data1,
    input  logic                  sig_valid,
    input  logic [SEM_IDX_W-1:0]  sig_idx,
    input  logic [SEM_IDX_W-1:0]  sem_rd_idx,
    output logic [SEM_VAL_W-1:0]  sem_rd_data,
    output logic [SEM_NUM-1:0]    evt_bits,
    output logic                  retire,
    output logic                  err
);

    exec_state_e                      state_q, state_d;
    cond_t    [N_COND-1:0]            dec_conds, conds_q;
    upd_cmd_t                         dec_upd, upd_q;
    logic                             dec_bad, bad_q;
    logic     [N_COND-1:0]            met;
    logic     [N_COND-1:0][SEM_IDX_W-1:0] cnt_idx;
    logic     [N_COND-1:0][SEM_VAL_W-1:0] cnt_val;
    logic     [N_COND-1:0][RF_AW-1:0]     rf_addr_w;
    logic     [N_COND-1:0][SEM_VAL_W-1:0] rf_data_w;
    logic                             accept, release_c, fault_c, apply;
    logic                             retire_q, err_q;

    sem_exec_decode u_dec (
        .insn  (in_insn),
        .conds (dec_conds),
        .upd   (dec_upd),
        .bad   (dec_bad)
    );

    assign rf_data_w = {rf_data1, rf_data0};
    assign rf_addr0  = rf_addr_w[0];
    assign rf_addr1  = rf_addr_w[1];

    genvar k;
    generate
        for (k = 0; k < N_COND; k++) begin : g_cond
            assign cnt_idx[k] = conds_q[k].idx;
            sem_exec_cond #(.RF_AW(RF_AW)) u_cond (
                .mode    (conds_q[k].mode),
                .thr     (conds_q[k].thr),
                .cnt     (cnt_val[k]),
                .rf_data (rf_data_w[k]),
                .rf_addr (rf_addr_w[k]),
                .met     (met[k])
            );
        end
    endgenerate

    assign accept    = (state_q == ST_IDLE) && in_valid;
    assign fault_c   = (state_q == ST_WAIT) && bad_q;
    assign release_c = (state_q == ST_WAIT) && !bad_q && (&met);
    assign apply     = release_c;

    sem_exec_bank #(.NRD(N_COND)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .cmd       (upd_q),
        .sig_valid (sig_valid),
        .sig_idx   (sig_idx),
        .rd_idx    (cnt_idx),
        .rd_data   (cnt_val),
        .obs_idx   (sem_rd_idx),
        .obs_data  (sem_rd_data),
        .evt_bits  (evt_bits)
    );

    // next-state logic: accept, fault, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_WAIT;
            ST_WAIT: if (fault_c || release_c) state_d = ST_IDLE;
        endcase
    end

    // state register and captured instruction
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            conds_q <= '0;
            upd_q   <= '0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                conds_q <= dec_conds;
                upd_q   <= dec_upd;
                bad_q   <= dec_bad;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retire_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            retire_q <= fault_c || release_c;
            err_q    <= fault_c;
        end
    end

    assign in_ready = (state_q == ST_IDLE);
    assign retire   = retire_q;
    assign err      = err_q;

endmodule

// File: rtl/sem_exec_chk.sv
module sem_exec_chk
    import sem_exec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               retire,
    input logic               err,
    input logic [SEM_NUM-1:0] evt_bits
);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_idle_at_retire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> in_ready);

    p_retire_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    p_err_needs_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> retire);

    p_events_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_bits) & ~evt_bits) == '0));

    p_events_on_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(evt_bits) |-> (retire && !err));

endmodule

bind sem_exec_top sem_exec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .retire   (retire),
    .err      (err),
    .evt_bits (evt_bits)
);

// File: tb/sem_exec_top_tb_top.sv
module sem_exec_top_tb_top;

    localparam int RF_AW = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [511:0] in_insn = '0;
    logic [3:0]   rf_addr0, rf_addr1;
    logic [31:0]  rf_data0, rf_data1;
    logic         sig_valid = 1'b0;
    logic [7:0]   sig_idx = '0;
    logic [7:0]   sem_rd_idx = '0;
    logic [31:0]  sem_rd_data;
    logic [255:0] evt_bits;
    logic         retire, err;

    logic [31:0]  rf [16];
    assign rf_data0 = rf[rf_addr0];
    assign rf_data1 = rf[rf_addr1];

    always #4 clk = ~clk;

    sem_exec_top #(.RF_AW(RF_AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .rf_addr0(rf_addr0), .rf_data0(rf_data0),
        .rf_addr1(rf_addr1), .rf_data1(rf_data1), .sig_valid(sig_valid),
        .sig_idx(sig_idx), .sem_rd_idx(sem_rd_idx), .sem_rd_data(sem_rd_data),
        .evt_bits(evt_bits), .retire(retire), .err(err)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // ---------------- behavioural reference model ----------------
    int unsigned  m_cnt [256];
    logic [255:0] m_evt = '0;
    bit           m_busy = 0;
    bit           m_retire = 0;
    bit           m_err = 0;
    logic [511:0] m_word = '0;

    function automatic logic [7:0] byt(input logic [511:0] w, input int k);
        return w[8*k +: 8];
    endfunction

    function automatic logic [31:0] dw(input logic [511:0] w, input int k);
        return w[8*k +: 32];
    endfunction

    function automatic bit mode_ok(input logic [7:0] m);
        return (m == 8'h00) || (m == 8'h05) || (m == 8'h85);
    endfunction

    function automatic bit m_is_bad(input logic [511:0] w);
        logic [7:0] u;
        u = byt(w, 34);
        if (byt(w, 0) != 8'hA0 || byt(w, 1) != 8'h10 || byt(w, 2) != 0 || byt(w, 3) != 0) return 1;
        if (!mode_ok(byt(w, 4)) || !mode_ok(byt(w, 32))) return 1;
        return !(u == 8'h00 || u == 8'h11 || u == 8'h13 || u == 8'h14 ||
                 u == 8'h15 || u == 8'h17 || u == 8'h19);
    endfunction

    function automatic bit m_holds(input logic [7:0] m, input logic [7:0] i, input logic [31:0] t);
        int unsigned lim;
        if (m == 8'h00) return 1;
        lim = (m == 8'h85) ? rf[t[3:0]] : t;
        return m_cnt[i] >= lim;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_evt = '0; m_busy = 0; m_retire = 0; m_err = 0;
        end else begin
            m_retire = 0;
            m_err = 0;
            if (!m_busy) begin
                if (in_valid) begin
                    m_busy = 1;
                    m_word = in_insn;
                end
            end else if (m_is_bad(m_word)) begin
                m_retire = 1; m_err = 1; m_busy = 0;
            end else if (m_holds(byt(m_word, 4), byt(m_word, 5), dw(m_word, 8)) &&
                         m_holds(byt(m_word, 32), byt(m_word, 33), dw(m_word, 36))) begin
                logic [7:0] ui;
                int unsigned uv;
                ui = byt(m_word, 35);
                uv = dw(m_word, 40);
                case (byt(m_word, 34))
                    8'h15: m_cnt[ui] = m_cnt[ui] + uv;
                    8'h17: m_cnt[ui] = m_cnt[ui] - uv;
                    8'h13: m_cnt[ui] = m_cnt[ui] + 1;
                    8'h14: m_cnt[ui] = m_cnt[ui] - 1;
                    8'h19: m_cnt[ui] = uv;
                    8'h11: m_evt[ui] = 1'b1;
                    default: ;
                endcase
                m_retire = 1; m_busy = 0;
            end
            if (sig_valid) m_cnt[sig_idx] = m_cnt[sig_idx] + 1;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2 in_ready vs model", {31'b0, in_ready}, {31'b0, !m_busy});
            chk("R11 retire vs model", {31'b0, retire}, {31'b0, m_retire});
            chk("R10 err vs model", {31'b0, err}, {31'b0, m_err});
            chk("R13 counter vs model", sem_rd_data, m_cnt[sem_rd_idx]);
            total++;
            if (evt_bits !== m_evt) begin
                bad++;
                $display("FAIL R9 events actual=%h expected=%h", evt_bits, m_evt);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<20000 cycles", cyc);
            finish_run();
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [511:0] mk(
        input logic [7:0] m0, input logic [7:0] i0, input logic [31:0] t0,
        input logic [7:0] m1, input logic [7:0] i1, input logic [31:0] t1,
        input logic [7:0] um, input logic [7:0] ui, input logic [31:0] uv);
        logic [511:0] w;
        w = '0;
        w[7:0] = 8'hA0; w[15:8] = 8'h10;
        w[8*4 +: 8] = m0; w[8*5 +: 8] = i0; w[8*8 +: 32] = t0;
        w[8*32 +: 8] = m1; w[8*33 +: 8] = i1; w[8*36 +: 32] = t1;
        w[8*34 +: 8] = um; w[8*35 +: 8] = ui; w[8*40 +: 32] = uv;
        return w;
    endfunction

    task automatic send(input logic [511:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_insn = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_retire(output int n, output logic e);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!retire && n < 300);
        e = err;
    endtask

    task automatic peek(input string req, input logic [7:0] idx, input logic [31:0] exp);
        sem_rd_idx = idx;
        #1;
        chk(req, sem_rd_data, exp);
    endtask

    task automatic pulse(input logic [7:0] idx, input int times);
        sig_valid = 1'b1;
        sig_idx = idx;
        repeat (times) @(negedge clk);
        sig_valid = 1'b0;
    endtask

    initial begin
        int n;
        logic e;
        logic [511:0] w;
        for (int i = 0; i < 16; i++) rf[i] = i + 3;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2 reset in_ready", {31'b0, in_ready}, 32'd1);
        chk("R2 reset retire", {31'b0, retire}, 32'd0);
        chk("R2 reset err", {31'b0, err}, 32'd0);
        peek("R2 reset counter", 8'd0, 32'd0);
        chk("R2 reset events", {31'b0, |evt_bits}, 32'd0);

        // R7 overwrite, R11 no-condition timing
        send(mk(0,0,0, 0,0,0, 8'h19, 8'd3, 32'd100));
        #1 chk("R2 busy after accept", {31'b0, in_ready}, 32'd0);
        wait_retire(n, e);
        chk("R11 no-condition retire latency", n, 32'd1);
        peek("R7 overwrite", 8'd3, 32'd100);

        // R4 immediate threshold, R8 inc ignores value
        send(mk(8'h05, 8'd5, 32'd3, 0,0,0, 8'h13, 8'd6, 32'h500));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R4 stalled below threshold", {31'b0, retire}, 32'd0);
        end
        peek("R11 no early update", 8'd6, 32'd0);
        pulse(8'd5, 3);
        wait_retire(n, e);
        peek("R8 increment ignores value", 8'd6, 32'd1);

        // R7 wrap, R5 register threshold, R3 second condition fields
        send(mk(0,0,0, 0,0,0, 8'h19, 8'd8, 32'hFFFF_FFFF));
        wait_retire(n, e);
        send(mk(8'h05, 8'd5, 32'd3, 8'h85, 8'd7, 32'd2, 8'h15, 8'd8, 32'd5));
        pulse(8'd7, 2);
        repeat (2) @(negedge clk);
        #1 chk("R5 register threshold not yet met", {31'b0, retire}, 32'd0);
        pulse(8'd7, 3);
        wait_retire(n, e);
        chk("R3 second condition released", {31'b0, e}, 32'd0);
        peek("R7 add wraps", 8'd8, 32'd4);

        // R8 decrement, R7 subtract
        send(mk(0,0,0, 0,0,0, 8'h14, 8'd9, 32'h1234));
        wait_retire(n, e);
        peek("R8 decrement wraps, value ignored", 8'd9, 32'hFFFF_FFFF);
        send(mk(0,0,0, 8'h05, 8'd3, 32'd100, 8'h17, 8'd3, 32'd30));
        wait_retire(n, e);
        peek("R7 subtract", 8'd3, 32'd70);

        // R9 event set
        send(mk(0,0,0, 0,0,0, 8'h11, 8'd200, 32'd9));
        wait_retire(n, e);
        #1 chk("R9 event bit set", {31'b0, evt_bits[200]}, 32'd1);
        peek("R9 counter untouched", 8'd200, 32'd0);

        // R6 illegal condition modes
        send(mk(8'h01, 8'd5, 32'd0, 0,0,0, 8'h19, 8'd3, 32'd999));
        wait_retire(n, e);
        chk("R6 equality mode flagged", {31'b0, e}, 32'd1);
        chk("R6 prompt retire", n, 32'd1);
        send(mk(0,0,0, 8'h07, 8'd5, 32'd0, 8'h19, 8'd3, 32'd999));
        wait_retire(n, e);
        chk("R6 event-wait mode flagged", {31'b0, e}, 32'd1);
        peek("R6 no side effect", 8'd3, 32'd70);

        // R10 unknown update code, with an unmet condition
        send(mk(8'h05, 8'd50, 32'd9, 0,0,0, 8'h16, 8'd3, 32'd5));
        wait_retire(n, e);
        chk("R10 unknown code flagged", {31'b0, e}, 32'd1);
        chk("R10 prompt retire", n, 32'd1);
        peek("R10 no side effect", 8'd3, 32'd70);
        send(mk(0,0,0, 0,0,0, 8'h00, 8'd3, 32'd5));
        wait_retire(n, e);
        chk("R10 empty update no error", {31'b0, e}, 32'd0);
        peek("R10 empty update no change", 8'd3, 32'd70);

        // R1 header checks
        w = mk(0,0,0, 0,0,0, 8'h19, 8'd3, 32'd1);
        w[15:8] = 8'h11;
        send(w);
        wait_retire(n, e);
        chk("R1 bad length flagged", {31'b0, e}, 32'd1);
        w = mk(0,0,0, 0,0,0, 8'h19, 8'd3, 32'd1);
        w[7:0] = 8'hA1;
        send(w);
        wait_retire(n, e);
        chk("R1 bad opcode flagged", {31'b0, e}, 32'd1);
        w = mk(0,0,0, 0,0,0, 8'h19, 8'd3, 32'd1);
        w[23:16] = 8'h01;
        send(w);
        wait_retire(n, e);
        chk("R1 reserved header byte flagged", {31'b0, e}, 32'd1);
        peek("R1 no side effect", 8'd3, 32'd70);

        // R12 collisions
        send(mk(0,0,0, 0,0,0, 8'h19, 8'd10, 32'd50));
        sig_valid = 1'b1; sig_idx = 8'd10;
        @(negedge clk);
        sig_valid = 1'b0;
        #1 chk("R12 retire at collision", {31'b0, retire}, 32'd1);
        peek("R12 overwrite plus bump", 8'd10, 32'd51);
        send(mk(0,0,0, 0,0,0, 8'h13, 8'd10, 32'd0));
        sig_valid = 1'b1; sig_idx = 8'd10;
        @(negedge clk);
        sig_valid = 1'b0;
        peek("R12 increment plus bump", 8'd10, 32'd53);
        send(mk(8'h05, 8'd11, 32'd1, 0,0,0, 8'h19, 8'd12, 32'd7));
        sig_valid = 1'b1; sig_idx = 8'd11;
        @(negedge clk);
        sig_valid = 1'b0;
        #1 chk("R12 condition sees pre-bump value", {31'b0, retire}, 32'd0);
        @(negedge clk);
        #1 chk("R12 release one edge later", {31'b0, retire}, 32'd1);
        peek("R12 update after bump", 8'd12, 32'd7);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule